// File: doc/BRIEF.md
# Two-Wire Serial Program/Verify Target

This block is the target side of a two-wire programming port. A host drives a clock pin and a data pin. The block reads 6-bit commands from the data pin and moves 16-cycle data frames in both directions on the same pin. It decodes each command and keeps a program counter (PC) that follows a split address map: user space and configuration space. It also issues program and erase operations to a behavioural non-volatile word array. The pins are oversampled by a fast system clock. Entering programming mode is modelled by the reset input. Reset clears every piece of control state and leaves the array contents as they were.

Erase and programming durations are counted in system clocks. The configuration window sits at C = 2^REGION_BITS (0x2000 by default). User words repeat every USER_WORDS locations. When the protect bit is cleared, user locations read as zero, and programming of user locations is refused until a bulk erase.

Top module: `spv_target`

## Requirements
- R1: A command takes 6 falling edges of the pin clock. Bits are taken least significant first. Only the low four bits are decoded, and the top two bits are don't care: 0000 = set PC to config base, 0010 = load word, 0100 = read word, 0110 = step PC, 1000 = start program, 1001 = bulk erase, 1110 = finish program.
- R2: A load frame takes 16 falling edges. Edge 1 is a start bit and edge 16 is a stop bit. Edges 2 to 15 latch data bits 0 to 13 in that order.
- R3: On a read, the data output is enabled at the 2nd rising edge of the frame and shows bit 0 there. Each later rising edge up to the 15th shows the next bit. The output is released at the 16th rising edge. At any other time the output is not enabled.
- R4: Reset sets the PC to 0. The step command adds one. The set-config-base command puts the PC at C and ignores its frame's data.
- R5: In user space the PC wraps from C-1 to 0. In config space it wraps from 2C-1 to C. Once the PC bit at position REGION_BITS is set, it stays set until reset.
- R6: Addresses C..C+31 are the config window. C+0..C+3 are writable ID words, C+6 is the read-only DEVICE_ID and C+7 is the config word. C+4, C+5 and C+8..C+31 read 0x3FFF. Config-space addresses above C+31 alias user words.
- R7: The user word index is the address modulo USER_WORDS.
- R8: Start program writes the loaded word ANDed into the addressed location. It is refused unless a load has completed since the last accepted start. Busy rises at an accepted start and falls at finish program.
- R9: While busy, every command except finish program (during a program) has no effect. Its frame is still consumed, and a read leaves the output disabled.
- R10: An accepted bulk erase holds busy for exactly ERASE_CYCLES clocks. It sets every user and config word to 0x3FFF, which also clears protection.
- R11: When bit 4 of the config word (C+7) is 0, user words read as 0x0000. Config words stay readable and writable.
- R12: After reset, busy and output enable are low, and the array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Active-low mode-entry reset |
| pgm_clk_i | input | 1 | Host programming clock pin |
| pgm_dat_i | input | 1 | Data pin, input side |
| pgm_dat_o | output | 1 | Data pin, output value |
| pgm_dat_oe | output | 1 | Data pin output enable |
| busy_o | output | 1 | Programming or erase in progress |

## Verification
The words read back use alternating-bit patterns (0x2AAA, 0x1555) and mixed nibbles. These separate a bit-order or off-by-one-edge error in the load and read frames from a stuck data line. Programming a word over an existing one tells AND-style programming apart from a plain overwrite. Long runs of step commands reach both wrap points, and the results tell a sticky config bit from a flat 14-bit counter. Commands sent while busy are chosen so that each one, if wrongly accepted, would change a later read or the busy flag.

// File: rtl/spv_pkg.sv
package spv_pkg;
   localparam int WORD_W     = 14;
   localparam int CMD_BITS   = 6;
   localparam int FRAME_BITS = 16;
   localparam int CNT_W      = $clog2(FRAME_BITS);
   localparam int CFG_SLOTS  = 8;
   localparam logic [WORD_W-1:0] ERASED = {WORD_W{1'b1}};

   typedef enum logic [3:0] {
      OP_LDCFG = 4'b0000,
      OP_LOAD  = 4'b0010,
      OP_READ  = 4'b0100,
      OP_INC   = 4'b0110,
      OP_BEGIN = 4'b1000,
      OP_ERASE = 4'b1001,
      OP_END   = 4'b1110
   } spv_op_e;

   typedef enum logic {PH_CMD, PH_DATA} spv_phase_e;
endpackage

// File: rtl/spv_sync.sv
module spv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_clk_i,
   input  logic pin_dat_i,
   output logic dat_o,
   output logic rise_o,
   output logic fall_o
);
   logic [1:0] chain [STAGES];
   logic       clk_prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 2'b00;
            else        chain[g] <= {pin_clk_i, pin_dat_i};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 2'b00;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= chain[STAGES-1][1];
   end

   assign dat_o  = chain[STAGES-1][0];
   assign rise_o = chain[STAGES-1][1] & ~clk_prev;
   assign fall_o = ~chain[STAGES-1][1] & clk_prev;

   p_edge_follows_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !clk_prev);
endmodule

// File: rtl/spv_pc.sv
module spv_pc #(
   parameter int REGION_BITS = 13
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   inc_i,
   input  logic                   cfg_i,
   output logic [REGION_BITS:0]   pc_o
);
   localparam int PC_W = REGION_BITS + 1;
   localparam logic [PC_W-1:0] CFG_BASE = PC_W'(1) << REGION_BITS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pc_o <= '0;
      else if (cfg_i) pc_o <= CFG_BASE;
      else if (inc_i) pc_o <= {pc_o[REGION_BITS], pc_o[REGION_BITS-1:0] + 1'b1};
   end

   p_cfg_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_o[REGION_BITS] |=> pc_o[REGION_BITS]);
   p_cfg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_i |=> pc_o == CFG_BASE);
   p_user_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !cfg_i && !pc_o[REGION_BITS] && (&pc_o[REGION_BITS-1:0])) |=> pc_o == '0);
endmodule

// File: rtl/spv_mem.sv
module spv_mem import spv_pkg::*; #(
   parameter int                REGION_BITS  = 13,
   parameter int                USER_WORDS   = 2048,
   parameter int                ERASE_CYCLES = 4096,
   parameter logic [WORD_W-1:0] DEVICE_ID    = 14'h00A0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [REGION_BITS:0]   addr_i,
   input  logic                   prog_i,
   input  logic [WORD_W-1:0]      wdata_i,
   input  logic                   erase_i,
   output logic [WORD_W-1:0]      rdata_o,
   output logic                   erase_busy_o
);
   localparam int AW = $clog2(USER_WORDS);
   localparam int EW = $clog2(ERASE_CYCLES + 1);
   localparam logic [EW-1:0] UW_E   = EW'(USER_WORDS);
   localparam logic [EW-1:0] SWEEP  = EW'(USER_WORDS + CFG_SLOTS);
   localparam logic [EW-1:0] LAST_E = EW'(ERASE_CYCLES - 1);

   logic [WORD_W-1:0] user_q [USER_WORDS];
   logic [WORD_W-1:0] cfg_q  [CFG_SLOTS];
   logic [EW-1:0]     ecnt;
   logic [EW-1:0]     coff;
   logic              ebusy;

   logic          cfg_sel, cfg_hit, cfg_wr_ok, protect;
   logic [2:0]    slot;
   logic [AW-1:0] uidx;

   assign cfg_sel   = addr_i[REGION_BITS] && (addr_i[REGION_BITS-1:5] == '0);
   assign cfg_hit   = cfg_sel && (addr_i[4:3] == 2'b00);
   assign slot      = addr_i[2:0];
   assign uidx      = addr_i[AW-1:0];
   assign cfg_wr_ok = cfg_hit && (slot[2] == 1'b0 || slot == 3'd7);
   assign protect   = ~cfg_q[7][4];
   assign coff      = ecnt - UW_E;

   always_comb begin
      if (cfg_sel) begin
         if (!cfg_hit) rdata_o = ERASED;
         else begin
            case (slot)
               3'd4, 3'd5: rdata_o = ERASED;
               3'd6:       rdata_o = DEVICE_ID;
               default:    rdata_o = cfg_q[slot];
            endcase
         end
      end else begin
         rdata_o = protect ? '0 : user_q[uidx];
      end
   end

   // erase sequencer: one word per clock, user space first, then config
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ebusy <= 1'b0;
         ecnt  <= '0;
      end else if (erase_i && !ebusy) begin
         ebusy <= 1'b1;
         ecnt  <= '0;
      end else if (ebusy) begin
         if (ecnt == LAST_E) ebusy <= 1'b0;
         ecnt <= ecnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ebusy) begin
         if (ecnt < UW_E)       user_q[ecnt[AW-1:0]] <= ERASED;
         else if (ecnt < SWEEP) cfg_q[coff[2:0]]     <= ERASED;
      end else if (prog_i) begin
         if (cfg_sel) begin
            if (cfg_wr_ok) cfg_q[slot] <= cfg_q[slot] & wdata_i;
         end else if (!protect) begin
            user_q[uidx] <= user_q[uidx] & wdata_i;
         end
      end
   end

   assign erase_busy_o = ebusy;

   p_erase_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_i && !ebusy) |=> ebusy);
   p_erase_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ebusy) |-> $past(ecnt) == LAST_E);
endmodule

// File: rtl/spv_link.sv
module spv_link import spv_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              dat_i,
   input  logic              erase_busy_i,
   input  logic [WORD_W-1:0] rdata_i,
   output logic              pc_inc_o,
   output logic              pc_cfg_o,
   output logic              prog_o,
   output logic              erase_o,
   output logic [WORD_W-1:0] wdata_o,
   output logic              dat_o,
   output logic              oe_o,
   output logic              prog_busy_o
);
   localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
   localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(WORD_W);

   spv_phase_e        phase;
   spv_op_e           op_q;
   logic              act_q, loaded_q, pbusy_q;
   logic [CNT_W-1:0]  cnt;
   logic [CMD_BITS-1:0] cmd_sh, cmd_full;
   logic [WORD_W-1:0] wsh, rsh;
   logic [3:0]        code;
   logic              busy, has_frame;

   assign busy      = pbusy_q | erase_busy_i;
   assign cmd_full  = {dat_i, cmd_sh[CMD_BITS-1:1]};
   assign code      = cmd_full[3:0];
   assign has_frame = (code == OP_LDCFG) || (code == OP_LOAD) || (code == OP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         op_q     <= OP_INC;
         act_q    <= 1'b0;
         loaded_q <= 1'b0;
         pbusy_q  <= 1'b0;
         cnt      <= '0;
         cmd_sh   <= '0;
         wsh      <= '0;
         rsh      <= '0;
         wdata_o  <= '0;
         dat_o    <= 1'b0;
         oe_o     <= 1'b0;
         pc_inc_o <= 1'b0;
         pc_cfg_o <= 1'b0;
         prog_o   <= 1'b0;
         erase_o  <= 1'b0;
      end else begin
         pc_inc_o <= 1'b0;
         pc_cfg_o <= 1'b0;
         prog_o   <= 1'b0;
         erase_o  <= 1'b0;
         if (phase == PH_CMD) begin
            if (fall_i) begin
               cmd_sh <= cmd_full;
               if (cnt == CMD_LAST) begin
                  cnt <= '0;
                  if (has_frame) begin
                     phase <= PH_DATA;
                     op_q  <= spv_op_e'(code);
                     act_q <= !busy;
                     rsh   <= rdata_i;
                  end else if (!busy) begin
                     case (code)
                        OP_INC:   pc_inc_o <= 1'b1;
                        OP_BEGIN: if (loaded_q) begin
                                     prog_o   <= 1'b1;
                                     pbusy_q  <= 1'b1;
                                     loaded_q <= 1'b0;
                                  end
                        OP_ERASE: erase_o <= 1'b1;
                        default:  ;
                     endcase
                  end else if (code == OP_END && pbusy_q) begin
                     pbusy_q <= 1'b0;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end else begin
            if (rise_i && op_q == OP_READ && act_q) begin
               if (cnt == FRAME_LAST) begin
                  oe_o  <= 1'b0;
                  dat_o <= 1'b0;
               end else if (cnt != '0) begin
                  oe_o  <= 1'b1;
                  dat_o <= rsh[0];
                  rsh   <= rsh >> 1;
               end
            end
            if (fall_i) begin
               if (cnt != '0 && cnt <= BIT_LAST) wsh <= {dat_i, wsh[WORD_W-1:1]};
               if (cnt == FRAME_LAST) begin
                  phase <= PH_CMD;
                  cnt   <= '0;
                  if (act_q && op_q == OP_LOAD) begin
                     wdata_o  <= wsh;
                     loaded_q <= 1'b1;
                  end else if (act_q && op_q == OP_LDCFG) begin
                     pc_cfg_o <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   assign prog_busy_o = pbusy_q;

   p_oe_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o |-> (phase == PH_DATA && op_q == OP_READ && act_q));
   p_prog_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      prog_o |-> ($past(loaded_q) && !$past(busy)));
   p_erase_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      erase_o |-> !$past(busy));
   p_busy_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_inc_o |-> !$past(busy));
endmodule

// File: rtl/spv_target.sv
module spv_target import spv_pkg::*; #(
   parameter int                REGION_BITS  = 13,
   parameter int                USER_WORDS   = 2048,
   parameter int                ERASE_CYCLES = 4096,
   parameter int                SYNC_STAGES  = 2,
   parameter logic [WORD_W-1:0] DEVICE_ID    = 14'h00A0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pgm_clk_i,
   input  logic pgm_dat_i,
   output logic pgm_dat_o,
   output logic pgm_dat_oe,
   output logic busy_o
);
   if (REGION_BITS < 6 || REGION_BITS > 16) begin : g_bad_region
      $error("REGION_BITS out of range");
   end
   if (USER_WORDS < 16 || (USER_WORDS & (USER_WORDS - 1)) != 0 || USER_WORDS > (1 << REGION_BITS)) begin : g_bad_words
      $error("USER_WORDS must be a power of two within the user region");
   end
   if (ERASE_CYCLES < USER_WORDS + CFG_SLOTS) begin : g_bad_erase
      $error("ERASE_CYCLES too short for the erase sweep");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                  s_dat, s_rise, s_fall;
   logic                  pc_inc, pc_cfg, prog, erase, erase_busy, prog_busy;
   logic [REGION_BITS:0]  pc;
   logic [WORD_W-1:0]     rdata, wdata;

   spv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_clk_i(pgm_clk_i), .pin_dat_i(pgm_dat_i),
      .dat_o(s_dat), .rise_o(s_rise), .fall_o(s_fall));

   spv_link u_link (
      .clk(clk), .rst_n(rst_n), .rise_i(s_rise), .fall_i(s_fall), .dat_i(s_dat),
      .erase_busy_i(erase_busy), .rdata_i(rdata), .pc_inc_o(pc_inc), .pc_cfg_o(pc_cfg),
      .prog_o(prog), .erase_o(erase), .wdata_o(wdata), .dat_o(pgm_dat_o),
      .oe_o(pgm_dat_oe), .prog_busy_o(prog_busy));

   spv_pc #(.REGION_BITS(REGION_BITS)) u_pc (
      .clk(clk), .rst_n(rst_n), .inc_i(pc_inc), .cfg_i(pc_cfg), .pc_o(pc));

   spv_mem #(.REGION_BITS(REGION_BITS), .USER_WORDS(USER_WORDS),
             .ERASE_CYCLES(ERASE_CYCLES), .DEVICE_ID(DEVICE_ID)) u_mem (
      .clk(clk), .rst_n(rst_n), .addr_i(pc), .prog_i(prog), .wdata_i(wdata),
      .erase_i(erase), .rdata_o(rdata), .erase_busy_o(erase_busy));

   assign busy_o = prog_busy | erase_busy;

   p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pgm_dat_oe && !busy_o));
endmodule

// File: tb/tb_spv_target.sv
module tb_spv_target;
   localparam int RB = 8;
   localparam int UW = 64;
   localparam int EC = 200;
   localparam int H  = 4;
   localparam logic [13:0] DEV = 14'h0A5C;

   localparam logic [5:0] C_LDCFG = 6'h00, C_LOAD = 6'h02, C_READ = 6'h04,
                          C_INC = 6'h06, C_BEGIN = 6'h08, C_ERASE = 6'h09, C_END = 6'h0E;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pgm_clk_i = 1'b0;
   logic pgm_dat_i = 1'b0;
   logic pgm_dat_o, pgm_dat_oe, busy_o;

   int vectors = 0;
   int errors  = 0;
   int bcnt    = 0;

   always #5 clk = ~clk;

   spv_target #(.REGION_BITS(RB), .USER_WORDS(UW), .ERASE_CYCLES(EC), .DEVICE_ID(DEV)) dut (
      .clk(clk), .rst_n(rst_n), .pgm_clk_i(pgm_clk_i), .pgm_dat_i(pgm_dat_i),
      .pgm_dat_o(pgm_dat_o), .pgm_dat_oe(pgm_dat_oe), .busy_o(busy_o));

   always @(posedge clk) if (busy_o) bcnt++;

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      vectors++;
      errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1 (run did not complete)");
      finish_run();
   end

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic b);
      pgm_dat_i = b;
      repeat (2) @(negedge clk);
      pgm_clk_i = 1'b1;
      repeat (H) @(negedge clk);
      pgm_clk_i = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic cmd(input logic [5:0] c);
      for (int i = 0; i < 6; i++) pulse(c[i]);
      repeat (3) @(negedge clk);
   endtask

   task automatic load_frame(input logic [13:0] w);
      pulse(1'b0);
      for (int i = 0; i < 14; i++) pulse(w[i]);
      pulse(1'b0);
      repeat (3) @(negedge clk);
   endtask

   // read frame: samples the pin at the end of each high phase
   task automatic read_frame(input bit drive, input string req, output logic [13:0] w);
      int drives = 0;
      w = '0;
      for (int k = 1; k <= 16; k++) begin
         pgm_dat_i = 1'b0;
         repeat (2) @(negedge clk);
         pgm_clk_i = 1'b1;
         repeat (H) @(negedge clk);
         if (pgm_dat_oe) drives++;
         if (drive && k == 1)  chk({req, " R3 oe before 2nd rise"}, pgm_dat_oe, 0);
         if (drive && k == 16) chk({req, " R3 oe after 16th rise"}, pgm_dat_oe, 0);
         if (k >= 2 && k <= 15) w[k-2] = pgm_dat_o;
         pgm_clk_i = 1'b0;
         repeat (H) @(negedge clk);
      end
      chk({req, " R3 driven cycles"}, drives, drive ? 14 : 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic read_expect(input logic [13:0] exp, input string req);
      logic [13:0] got;
      cmd(C_READ);
      read_frame(1'b1, req, got);
      chk({req, " read word"}, got, exp);
   endtask

   task automatic load_word(input logic [13:0] w);
      cmd(C_LOAD);
      load_frame(w);
   endtask

   task automatic prog_word(input logic [13:0] w, input string req);
      load_word(w);
      cmd(C_BEGIN);
      chk({req, " R8 busy after start"}, busy_o, 1);
      cmd(C_END);
      chk({req, " R8 busy after finish"}, busy_o, 0);
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) cmd(C_INC);
   endtask

   task automatic go_cfg();
      cmd(C_LDCFG);
      load_frame(14'h0000);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pgm_clk_i = 1'b0;
      pgm_dat_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_erase(input string req);
      bcnt = 0;
      cmd(C_ERASE);
      chk({req, " R10 busy during erase"}, busy_o, 1);
      while (busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
      chk({req, " R10 erase busy length"}, bcnt, EC);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R12 oe after reset", pgm_dat_oe, 0);
      chk("R12 busy after reset", busy_o, 0);
   endtask

   task automatic t_erase();
      do_erase("erase1");
      read_expect(14'h3FFF, "R10 user word erased");
      go_cfg();
      step(7);
      read_expect(14'h3FFF, "R10 config word erased");
   endtask

   task automatic t_program();
      do_reset();
      prog_word(14'h1234, "R2 w0");
      read_expect(14'h1234, "R2 R3 word0");
      step(1);
      prog_word(14'h2AAA, "R2 w1");
      read_expect(14'h2AAA, "R2 R3 word1");
      step(1);
      prog_word(14'h1555, "R2 w2");
      read_expect(14'h1555, "R2 R3 word2");
      cmd(C_BEGIN);
      chk("R8 start without load refused", busy_o, 0);
      read_expect(14'h1555, "R8 word unchanged");
   endtask

   task automatic t_and();
      do_reset();
      read_expect(14'h1234, "R12 R4 contents kept, PC at 0");
      prog_word(14'h00FF, "R8 and");
      read_expect(14'h0034, "R8 programming ANDs");
   endtask

   task automatic t_busy_ignore();
      logic [13:0] got;
      load_word(14'h0F0F);
      cmd(C_BEGIN);
      chk("R9 busy set", busy_o, 1);
      cmd(C_INC);
      load_word(14'h0000);
      cmd(C_READ);
      read_frame(1'b0, "R9 read while busy", got);
      cmd(C_ERASE);
      cmd(C_END);
      chk("R9 erase while busy ignored", busy_o, 0);
      cmd(C_BEGIN);
      chk("R9 load while busy ignored", busy_o, 0);
      read_expect(14'h0004, "R9 PC and word unchanged");
   endtask

   task automatic t_upper_bits();
      logic [13:0] got;
      cmd(6'b110110);
      cmd(6'b100100);
      read_frame(1'b1, "R1 upper bits", got);
      chk("R1 upper bits ignored", got, 14'h2AAA);
   endtask

   task automatic t_cfg_map();
      go_cfg();
      cmd(C_BEGIN);
      chk("R4 config-base frame data discarded", busy_o, 0);
      read_expect(14'h3FFF, "R4 R6 ID0 at base");
      prog_word(14'h3FF5, "R6 id0");
      read_expect(14'h3FF5, "R6 ID0 programmed");
      step(4);
      read_expect(14'h3FFF, "R6 reserved slot 4");
      step(2);
      read_expect(DEV, "R6 device id");
      step(2);
      read_expect(14'h3FFF, "R6 unimplemented C+8");
      step(56);
      read_expect(14'h0004, "R6 alias above window");
   endtask

   task automatic t_alias();
      do_reset();
      step(UW);
      read_expect(14'h0004, "R7 index modulo size");
   endtask

   task automatic t_wrap();
      do_reset();
      step(1 << RB);
      read_expect(14'h0004, "R5 user wrap to 0");
      go_cfg();
      step(1 << RB);
      read_expect(14'h3FF5, "R5 config wrap sticky");
   endtask

   task automatic t_protect();
      do_reset();
      go_cfg();
      step(7);
      prog_word(14'h3FEF, "R11 cfg");
      read_expect(14'h3FEF, "R11 config word writable");
      do_reset();
      read_expect(14'h0000, "R11 protected user read");
      go_cfg();
      read_expect(14'h3FF5, "R11 config readable");
      do_erase("erase2");
      do_reset();
      read_expect(14'h3FFF, "R10 user erased");
      go_cfg();
      read_expect(14'h3FFF, "R10 ID0 erased");
      step(7);
      read_expect(14'h3FFF, "R10 R11 protection cleared");
   endtask

   initial begin
      t_reset();
      t_erase();
      t_program();
      t_and();
      t_busy_ignore();
      t_upper_bits();
      t_cfg_map();
      t_alias();
      t_wrap();
      t_protect();
      finish_run();
   end
endmodule